// File: doc/BRIEF.md
# Circuit-Switched Node Request and Reply Controller

This block sits between a processing element and one port of a bufferless, circuit-switched on-chip network switch. It plays both roles a node has in such a network. As a source it decides at random whether to start a transfer, draws a destination address, and raises a request that carries that address on the data lines. It then waits for the path to be granted or refused. A refusal makes it drop the request and wait a programmable number of cycles before it asks again for the same destination. A grant makes it stream a configured number of data words over the held path.

As a destination it watches the incoming side of the port. When it is idle and a request addressed to it arrives, it answers with a one-cycle clear-to-send pulse and then counts the arriving data words. When the configured packet length has been received, it emits a one-cycle release pulse that tears down every switch resource along the path. A 16-bit linear feedback shift register supplies both the start decision and the destination draw. The start probability is set in tenths, from never up to every opportunity, and an optional restricted mode limits destinations to a bit mask of allowed node addresses.

Top module: `noc_node_ctrl`

## Requirements
- R1: While and directly after reset, tx_req_out, tx_valid_out, tx_data_out, rx_cts_out, rx_release_out, rx_word_valid_out and rx_word_out are all zero.
- R2: In transmit idle, a start decision is taken each cycle with probability cfg_act_level/10 (values above 10 act as 10); a level of 0 never raises tx_req_out, and a level of 10 raises it within 64 cycles of entering idle when a legal destination exists.
- R3: While tx_req_out is high and tx_valid_out is low, tx_data_out holds the destination address, which is below cfg_node_count and never equal to cfg_node_id; an illegal draw is discarded and redrawn on a later cycle.
- R4: With cfg_restrict_en high, the destination is always an address whose bit in cfg_dest_mask is 1.
- R5: A pulse on tx_reject_in while waiting for a reply makes tx_req_out fall on the next cycle, stay low for exactly cfg_retry_dly+1 cycles, and rise again with the same destination on tx_data_out.
- R6: A pulse on tx_grant_in while waiting for a reply makes tx_valid_out high from the next cycle for exactly cfg_pkt_words consecutive cycles (0 counts as 1), with tx_data_out carrying word numbers 0,1,2,...; tx_req_out and tx_valid_out then fall together.
- R7: When the receiver is idle and rx_req_in is high with rx_data_in equal to cfg_node_id, rx_cts_out is high on the next cycle for exactly one cycle.
- R8: While the receiver is busy with a transfer, rx_req_in addressed to this node does not raise rx_cts_out.
- R9: Each cycle with rx_valid_in high during a transfer presents rx_data_in on rx_word_out with rx_word_valid_out high one cycle later; on the cycle the cfg_pkt_words-th word is presented, rx_release_out is high for that one cycle only.
- R10: An idle receiver ignores rx_req_in when rx_data_in differs from cfg_node_id: rx_cts_out stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_node_id | input | NODE_W | Address of this node |
| cfg_node_count | input | NODE_W+1 | Number of nodes in the network |
| cfg_act_level | input | 4 | Start probability in tenths |
| cfg_restrict_en | input | 1 | Restrict destinations to the mask |
| cfg_dest_mask | input | 2**NODE_W | Allowed destinations in restricted mode |
| cfg_retry_dly | input | DLY_W | Back-off delay after a refusal |
| cfg_pkt_words | input | LEN_W | Words per transfer |
| tx_grant_in | input | 1 | Path granted pulse |
| tx_reject_in | input | 1 | Path refused pulse |
| tx_req_out | output | 1 | Outgoing request, held while the path is used |
| tx_valid_out | output | 1 | Outgoing data word valid |
| tx_data_out | output | DATA_W | Destination address, then data words |
| rx_req_in | input | 1 | Incoming request |
| rx_valid_in | input | 1 | Incoming data word valid |
| rx_data_in | input | DATA_W | Incoming address, then data words |
| rx_cts_out | output | 1 | Clear-to-send pulse to the source |
| rx_release_out | output | 1 | Path release pulse |
| rx_word_valid_out | output | 1 | Received word valid |
| rx_word_out | output | DATA_W | Received word |

## Verification
A transmit state machine stuck in the wrong state shows within one cycle of a reply: a refusal that does not drop tx_req_out, or a grant that does not raise tx_valid_out, is seen on the very next sample, and a wrong back-off count shifts the re-request edge by whole cycles. A wrong word counter shows as a word number out of sequence or as a burst one word too long or short, and on the receive side as rx_release_out on the wrong word. A receiver that fails to leave idle answers a second request with a clear-to-send pulse during the transfer, which is visible on the next cycle.

// File: rtl/noc_node_pkg.sv
package noc_node_pkg;

  typedef enum logic [2:0] {
    TX_IDLE,
    TX_REQUEST,
    TX_WAIT_REPLY,
    TX_BACKOFF,
    TX_SEND
  } tx_state_e;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_CTS,
    RX_RECEIVE
  } rx_state_e;

endpackage

// File: rtl/noc_node_lfsr.sv
module noc_node_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] rnd
);

  logic [W-1:0] state_q;

  // Galois form: shift right, fold the taps in when the dropped bit is 1
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEED;
    end else if (state_q[0]) begin
      state_q <= (state_q >> 1) ^ TAPS;
    end else begin
      state_q <= state_q >> 1;
    end
  end

  assign rnd = state_q;

  // the draw source must never lock up at zero (R2 depends on it)
  assert_lfsr_alive_R2: assert property (@(posedge clk) disable iff (rst)
    state_q != '0);

endmodule

// File: rtl/noc_node_tx.sv
module noc_node_tx
  import noc_node_pkg::*;
#(
  parameter int NODE_W = 4,
  parameter int DATA_W = 8,
  parameter int LEN_W  = 16,
  parameter int DLY_W  = 8,
  parameter int RND_W  = 16,
  localparam int NODES = 1 << NODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RND_W-1:0]  rnd,
  input  logic [NODE_W-1:0] cfg_node_id,
  input  logic [NODE_W:0]   cfg_node_count,
  input  logic [3:0]        cfg_act_level,
  input  logic              cfg_restrict_en,
  input  logic [NODES-1:0]  cfg_dest_mask,
  input  logic [DLY_W-1:0]  cfg_retry_dly,
  input  logic [LEN_W-1:0]  cfg_pkt_words,
  input  logic              grant_in,
  input  logic              reject_in,
  output logic              req_out,
  output logic              valid_out,
  output logic [DATA_W-1:0] data_out
);

  tx_state_e         st_q;
  logic              pend_q;
  logic [NODE_W-1:0] dest_q;
  logic [DLY_W-1:0]  dly_q;
  logic [LEN_W-1:0]  idx_q;
  logic              req_q, valid_q;
  logic [DATA_W-1:0] data_q;

  logic              act_hit;
  logic [NODE_W-1:0] draw;
  logic              draw_ok;
  logic              last_word;

  // start when r*10 < level*256, r being an 8-bit random draw
  assign act_hit = ({4'b0, rnd[7:0]} * 12'd10) < {cfg_act_level, 8'h00};

  // destination scaled into 0 .. count-1 without a divider
  assign draw = NODE_W'((32'(rnd[RND_W-1 -: 8]) * 32'(cfg_node_count)) >> 8);

  assign draw_ok = (draw != cfg_node_id) &&
                   (!cfg_restrict_en || cfg_dest_mask[draw]);

  assign last_word = ({1'b0, idx_q} + 1'b1) >= {1'b0, cfg_pkt_words};

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= TX_IDLE;
      pend_q  <= 1'b0;
      dest_q  <= '0;
      dly_q   <= '0;
      idx_q   <= '0;
      req_q   <= 1'b0;
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      unique case (st_q)
        TX_IDLE: begin
          if (!pend_q) begin
            pend_q <= act_hit;
          end else if (draw_ok) begin
            pend_q <= 1'b0;
            dest_q <= draw;
            req_q  <= 1'b1;
            data_q <= DATA_W'(draw);
            st_q   <= TX_REQUEST;
          end
        end
        TX_REQUEST: begin
          st_q <= TX_WAIT_REPLY;
        end
        TX_WAIT_REPLY: begin
          if (grant_in) begin
            st_q    <= TX_SEND;
            valid_q <= 1'b1;
            idx_q   <= '0;
            data_q  <= '0;
          end else if (reject_in) begin
            st_q  <= TX_BACKOFF;
            req_q <= 1'b0;
            dly_q <= cfg_retry_dly;
          end
        end
        TX_BACKOFF: begin
          if (dly_q == '0) begin
            st_q   <= TX_REQUEST;
            req_q  <= 1'b1;
            data_q <= DATA_W'(dest_q);
          end else begin
            dly_q <= dly_q - 1'b1;
          end
        end
        TX_SEND: begin
          if (last_word) begin
            st_q    <= TX_IDLE;
            req_q   <= 1'b0;
            valid_q <= 1'b0;
            data_q  <= '0;
          end else begin
            idx_q  <= idx_q + 1'b1;
            data_q <= DATA_W'(idx_q + 1'b1);
          end
        end
        default: st_q <= TX_IDLE;
      endcase
    end
  end

  assign req_out   = req_q;
  assign valid_out = valid_q;
  assign data_out  = data_q;

  assert_valid_in_link_R6: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> req_q);

  assert_grant_starts_send_R6: assert property (@(posedge clk) disable iff (rst)
    (st_q == TX_WAIT_REPLY && grant_in) |=> valid_q);

  assert_reject_drops_req_R5: assert property (@(posedge clk) disable iff (rst)
    (st_q == TX_WAIT_REPLY && reject_in && !grant_in) |=> !req_q);

  assert_dest_not_self_R3: assert property (@(posedge clk) disable iff (rst)
    (req_q && !valid_q) |-> (32'(data_q) != 32'(cfg_node_id)));

  assert_dest_in_range_R3: assert property (@(posedge clk) disable iff (rst)
    (req_q && !valid_q) |-> (32'(data_q) < 32'(cfg_node_count)));

endmodule

// File: rtl/noc_node_rx.sv
module noc_node_rx
  import noc_node_pkg::*;
#(
  parameter int NODE_W = 4,
  parameter int DATA_W = 8,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NODE_W-1:0] cfg_node_id,
  input  logic [LEN_W-1:0]  cfg_pkt_words,
  input  logic              req_in,
  input  logic              valid_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              cts_out,
  output logic              release_out,
  output logic              word_valid_out,
  output logic [DATA_W-1:0] word_out
);

  rx_state_e         st_q;
  logic [LEN_W-1:0]  cnt_q;
  logic              cts_q, rel_q, wv_q;
  logic [DATA_W-1:0] word_q;
  logic              addressed;
  logic              last_word;

  assign addressed = req_in && (data_in == DATA_W'(cfg_node_id));
  assign last_word = ({1'b0, cnt_q} + 1'b1) >= {1'b0, cfg_pkt_words};

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      cts_q  <= 1'b0;
      rel_q  <= 1'b0;
      wv_q   <= 1'b0;
      word_q <= '0;
    end else begin
      cts_q <= 1'b0;
      rel_q <= 1'b0;
      wv_q  <= 1'b0;
      if (st_q == RX_IDLE) begin
        if (addressed) begin
          cts_q <= 1'b1;
          cnt_q <= '0;
          st_q  <= RX_CTS;
        end
      end else begin
        if (st_q == RX_CTS) st_q <= RX_RECEIVE;
        if (valid_in) begin
          wv_q   <= 1'b1;
          word_q <= data_in;
          if (last_word) begin
            rel_q <= 1'b1;
            st_q  <= RX_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end

  assign cts_out        = cts_q;
  assign release_out    = rel_q;
  assign word_valid_out = wv_q;
  assign word_out       = word_q;

  assert_cts_one_cycle_R7: assert property (@(posedge clk) disable iff (rst)
    cts_q |=> !cts_q);

  assert_busy_no_cts_R8: assert property (@(posedge clk) disable iff (rst)
    (st_q != RX_IDLE) |=> !cts_q);

  assert_release_one_cycle_R9: assert property (@(posedge clk) disable iff (rst)
    rel_q |=> !rel_q);

  assert_release_with_word_R9: assert property (@(posedge clk) disable iff (rst)
    rel_q |-> (wv_q && $past(valid_in)));

  assert_cts_release_apart_R7: assert property (@(posedge clk) disable iff (rst)
    !(cts_q && rel_q));

endmodule

// File: rtl/noc_node_ctrl.sv
module noc_node_ctrl #(
  parameter int NODE_W = 4,
  parameter int DATA_W = 8,
  parameter int LEN_W  = 16,
  parameter int DLY_W  = 8,
  localparam int NODES = 1 << NODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NODE_W-1:0] cfg_node_id,
  input  logic [NODE_W:0]   cfg_node_count,
  input  logic [3:0]        cfg_act_level,
  input  logic              cfg_restrict_en,
  input  logic [NODES-1:0]  cfg_dest_mask,
  input  logic [DLY_W-1:0]  cfg_retry_dly,
  input  logic [LEN_W-1:0]  cfg_pkt_words,
  input  logic              tx_grant_in,
  input  logic              tx_reject_in,
  output logic              tx_req_out,
  output logic              tx_valid_out,
  output logic [DATA_W-1:0] tx_data_out,
  input  logic              rx_req_in,
  input  logic              rx_valid_in,
  input  logic [DATA_W-1:0] rx_data_in,
  output logic              rx_cts_out,
  output logic              rx_release_out,
  output logic              rx_word_valid_out,
  output logic [DATA_W-1:0] rx_word_out
);

  localparam int RND_W = 16;

  logic [RND_W-1:0] rnd;

  noc_node_lfsr #(.W(RND_W)) u_lfsr (
    .clk (clk),
    .rst (rst),
    .rnd (rnd)
  );

  noc_node_tx #(
    .NODE_W(NODE_W), .DATA_W(DATA_W), .LEN_W(LEN_W),
    .DLY_W(DLY_W), .RND_W(RND_W)
  ) u_tx (
    .clk             (clk),
    .rst             (rst),
    .rnd             (rnd),
    .cfg_node_id     (cfg_node_id),
    .cfg_node_count  (cfg_node_count),
    .cfg_act_level   (cfg_act_level),
    .cfg_restrict_en (cfg_restrict_en),
    .cfg_dest_mask   (cfg_dest_mask),
    .cfg_retry_dly   (cfg_retry_dly),
    .cfg_pkt_words   (cfg_pkt_words),
    .grant_in        (tx_grant_in),
    .reject_in       (tx_reject_in),
    .req_out         (tx_req_out),
    .valid_out       (tx_valid_out),
    .data_out        (tx_data_out)
  );

  noc_node_rx #(
    .NODE_W(NODE_W), .DATA_W(DATA_W), .LEN_W(LEN_W)
  ) u_rx (
    .clk            (clk),
    .rst            (rst),
    .cfg_node_id    (cfg_node_id),
    .cfg_pkt_words  (cfg_pkt_words),
    .req_in         (rx_req_in),
    .valid_in       (rx_valid_in),
    .data_in        (rx_data_in),
    .cts_out        (rx_cts_out),
    .release_out    (rx_release_out),
    .word_valid_out (rx_word_valid_out),
    .word_out       (rx_word_out)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!tx_req_out && !tx_valid_out && !rx_cts_out && !rx_release_out));

endmodule

// File: tb/tb_noc_node_ctrl.sv
`timescale 1ns/1ps
module tb_noc_node_ctrl;

  localparam int NODE_W = 4;
  localparam int DATA_W = 8;
  localparam int LEN_W  = 16;
  localparam int DLY_W  = 8;
  localparam int NODES  = 1 << NODE_W;
  localparam int MY_ID  = 5;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NODE_W-1:0] cfg_node_id = NODE_W'(MY_ID);
  logic [NODE_W:0]   cfg_node_count = 5'd16;
  logic [3:0]        cfg_act_level = 4'd0;
  logic              cfg_restrict_en = 1'b0;
  logic [NODES-1:0]  cfg_dest_mask = '0;
  logic [DLY_W-1:0]  cfg_retry_dly = '0;
  logic [LEN_W-1:0]  cfg_pkt_words = 16'd1;
  logic              tx_grant_in = 1'b0, tx_reject_in = 1'b0;
  logic              tx_req_out, tx_valid_out;
  logic [DATA_W-1:0] tx_data_out;
  logic              rx_req_in = 1'b0, rx_valid_in = 1'b0;
  logic [DATA_W-1:0] rx_data_in = '0;
  logic              rx_cts_out, rx_release_out, rx_word_valid_out;
  logic [DATA_W-1:0] rx_word_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  noc_node_ctrl #(.NODE_W(NODE_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .DLY_W(DLY_W)) dut (
    .clk(clk), .rst(rst),
    .cfg_node_id(cfg_node_id), .cfg_node_count(cfg_node_count),
    .cfg_act_level(cfg_act_level), .cfg_restrict_en(cfg_restrict_en),
    .cfg_dest_mask(cfg_dest_mask), .cfg_retry_dly(cfg_retry_dly),
    .cfg_pkt_words(cfg_pkt_words),
    .tx_grant_in(tx_grant_in), .tx_reject_in(tx_reject_in),
    .tx_req_out(tx_req_out), .tx_valid_out(tx_valid_out), .tx_data_out(tx_data_out),
    .rx_req_in(rx_req_in), .rx_valid_in(rx_valid_in), .rx_data_in(rx_data_in),
    .rx_cts_out(rx_cts_out), .rx_release_out(rx_release_out),
    .rx_word_valid_out(rx_word_valid_out), .rx_word_out(rx_word_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit dest_legal(input int d, input bit restr, input logic [NODES-1:0] m,
                                    input int cnt);
    if (d == MY_ID || d >= cnt) return 1'b0;
    if (restr && !m[d]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    tx_grant_in = 0; tx_reject_in = 0; rx_req_in = 0; rx_valid_in = 0; rx_data_in = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // one full source transaction: request, random refusals, then a grant
  task automatic tx_round();
    int d;
    bit seen;
    seen = 1'b0;
    for (int w = 0; w < 64 && !seen; w++) begin
      @(negedge clk);
      seen = tx_req_out;
    end
    check(seen, "R2 request raised at level 10", int'(seen), 1);
    if (!seen) return;
    d = int'(tx_data_out);
    check(dest_legal(d, 1'b0, '0, int'(cfg_node_count)), "R3 destination legal", d, -1);
    if (cfg_restrict_en)
      check(cfg_dest_mask[d[NODE_W-1:0]] == 1'b1, "R4 destination in mask", d, -1);
    for (int tries = 0; tries < 8; tries++) begin
      int dly, pkt;
      bit rej;
      rej = (tries < 3) && ($urandom_range(0, 2) == 0);
      dly = $urandom_range(0, 5);
      pkt = $urandom_range(1, 6);
      cfg_retry_dly = DLY_W'(dly);
      cfg_pkt_words = LEN_W'(pkt);
      @(negedge clk);
      check(tx_req_out && !tx_valid_out, "R5 request held while waiting", int'(tx_req_out), 1);
      if (rej) tx_reject_in = 1'b1; else tx_grant_in = 1'b1;
      @(negedge clk);
      tx_reject_in = 1'b0;
      tx_grant_in  = 1'b0;
      if (rej) begin
        for (int k = 0; k <= dly; k++) begin
          check(!tx_req_out, "R5 request low during back-off", int'(tx_req_out), 0);
          @(negedge clk);
        end
        check(tx_req_out, "R5 request raised after back-off", int'(tx_req_out), 1);
        check(int'(tx_data_out) == d, "R5 same destination on retry", int'(tx_data_out), d);
      end else begin
        for (int i = 0; i < pkt; i++) begin
          check(tx_valid_out && tx_req_out, "R6 word valid", int'(tx_valid_out), 1);
          check(int'(tx_data_out) == i, "R6 word number", int'(tx_data_out), i);
          @(negedge clk);
        end
        check(!tx_valid_out && !tx_req_out, "R6 burst ends",
              int'({tx_req_out, tx_valid_out}), 0);
        return;
      end
    end
  endtask

  // one receive transfer addressed to this node
  task automatic rx_round(input int pkt);
    cfg_pkt_words = LEN_W'(pkt);
    rx_req_in  = 1'b1;
    rx_data_in = DATA_W'(MY_ID + 4);
    @(negedge clk);
    @(negedge clk);
    check(!rx_cts_out, "R10 foreign address ignored", int'(rx_cts_out), 0);
    rx_data_in = DATA_W'(MY_ID);
    @(negedge clk);
    check(rx_cts_out, "R7 clear-to-send raised", int'(rx_cts_out), 1);
    rx_data_in = 8'hA5;
    @(negedge clk);
    check(!rx_cts_out, "R7 clear-to-send one cycle", int'(rx_cts_out), 0);
    for (int i = 0; i < pkt; i++) begin
      int w;
      int gap;
      gap = $urandom_range(0, 2);
      for (int g = 0; g < gap; g++) begin
        rx_valid_in = 1'b0;
        rx_data_in  = DATA_W'(MY_ID);
        @(negedge clk);
        check(!rx_cts_out && !rx_release_out, "R8 busy receiver silent",
              int'({rx_cts_out, rx_release_out}), 0);
      end
      w = $urandom_range(0, 255);
      rx_valid_in = 1'b1;
      rx_data_in  = DATA_W'(w);
      if (i == pkt - 1) rx_req_in = 1'b0;
      @(negedge clk);
      rx_valid_in = 1'b0;
      check(rx_word_valid_out && int'(rx_word_out) == w, "R9 word delivered",
            int'(rx_word_out), w);
      check(rx_release_out == (i == pkt - 1), "R9 release on last word",
            int'(rx_release_out), int'(i == pkt - 1));
      check(!rx_cts_out, "R8 no clear-to-send while busy", int'(rx_cts_out), 0);
    end
    rx_data_in = '0;
    @(negedge clk);
    check(!rx_release_out && !rx_word_valid_out, "R9 release one cycle",
          int'(rx_release_out), 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 150000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int unsigned seed;
    bit any;
    seed = $urandom(32'd20240611);

    // R1 reset state
    do_reset();
    check(!tx_req_out && !tx_valid_out && tx_data_out == '0, "R1 transmit outputs at reset",
          int'(tx_data_out), 0);
    check(!rx_cts_out && !rx_release_out && !rx_word_valid_out && rx_word_out == '0,
          "R1 receive outputs at reset", int'(rx_word_out), 0);

    // R2 level 0 never starts
    any = 1'b0;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      any = any | tx_req_out;
    end
    check(!any, "R2 level 0 never requests", int'(any), 0);

    // R3 R5 R6 full network
    cfg_act_level = 4'd10;
    do_reset();
    for (int n = 0; n < 30; n++) tx_round();

    // R3 small network: draws must stay below 6
    cfg_node_count = 5'd6;
    do_reset();
    for (int n = 0; n < 10; n++) tx_round();

    // R4 restricted destinations
    cfg_node_count  = 5'd16;
    cfg_restrict_en = 1'b1;
    cfg_dest_mask   = 16'h0288;
    do_reset();
    for (int n = 0; n < 10; n++) tx_round();
    cfg_restrict_en = 1'b0;

    // R7 R8 R9 R10 receive side, transmitter parked
    cfg_act_level = 4'd0;
    do_reset();
    rx_round(1);
    rx_round(4);
    for (int n = 0; n < 3; n++) rx_round($urandom_range(2, 7));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule